// File: doc/BRIEF.md
# Daisy-Chain Serial DAC Host Controller

This block is the host side of a serial link to a chain of `CHAIN_LEN` digital-to-analog converters. The devices share one serial clock, one data line and one active-low select/load line, and each device's shift output feeds the data input of the next. A single request from the system makes the controller drop the select line, shift out one 16-bit word per device (`16 * CHAIN_LEN` bits in all) and raise the select line again. The rising edge of select makes every device in the chain load its word at once.

Each device takes a 16-bit word, sent most significant bit first. Bits 15:12 hold a 4-bit address or command, bits 11:2 hold a 10-bit code and bits 1:0 are pad bits. The controller does not buffer the words. It asks for them one at a time through a fetch port indexed by chain position, and it takes each word in the same cycle that it presents the index. Any position can be marked as parked. A parked position gets the sleep command instead of the fetched word on every update, so a device kept asleep stays asleep while its neighbours are rewritten.

Every timing minimum of the serial link is a nanosecond parameter. Each one is converted to whole system-clock cycles with rounding up, and the serial clock divider `SCK_DIV` sets a lower bound on both clock phases.

Top module: `dac_chain_master`

## Requirements
- R1: After reset `cs_n` is 1, `sck` is 0, `busy` is 0 and `done` is 0.
- R2: `sck` is 0 in the cycle before `cs_n` falls and in the cycle it falls. `sck` is never 1 while `cs_n` is 1. Each frame holds exactly `16*CHAIN_LEN` rising edges of `sck`.
- R3: Each word is shifted most significant bit first, and `din` is launched so that the devices sample it on the rising edge of `sck`.
- R4: Chain position `CHAIN_LEN-1`, the device farthest from the host, is sent first, and position 0 is sent last. `word_data` is taken in the cycle in which `word_idx` shows that position.
- R5: A position whose `park_mask` bit is 1 is sent the word 16'hE000 (address 1110, code 0, pad 0), whatever `word_data` holds.
- R6: `sck` stays high for at least `max(SCK_DIV, ceil(T_SCK_HIGH_NS/CLK_NS))` cycles. `sck` stays low for at least `max(SCK_DIV, ceil(T_SCK_LOW_NS/CLK_NS), ceil(T_DIN_SETUP_NS/CLK_NS))` cycles. `din` changes only while `sck` is low. The defaults give 2 cycles for each phase.
- R7: The first rise of `sck` comes at least `ceil(T_SEL_SETUP_NS/CLK_NS)` cycles (4) after `cs_n` falls. `cs_n` rises at least `ceil(T_SEL_HOLD_NS/CLK_NS)` cycles (2) after the last fall of `sck`.
- R8: `cs_n` stays high for at least `ceil(T_SEL_HIGH_NS/CLK_NS)` cycles (4) between frames, even when the requests come back to back.
- R9: A `req` seen while `busy` is 1 is ignored: it starts no frame and does not change the frame in progress.
- R10: `busy` is 1 from the cycle after a request is accepted until the select-high gap ends. `done` is 1 for exactly one cycle, one cycle after `cs_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start a frame; taken only when idle |
| busy | output | 1 | Frame or select-high gap in progress |
| done | output | 1 | One-cycle pulse after select rises |
| word_idx | output | IDX_W | Chain position whose word is fetched now |
| word_data | input | 16 | Word for the position on `word_idx` |
| park_mask | input | CHAIN_LEN | 1 = send the sleep command to that position |
| sck | output | 1 | Serial clock to the chain |
| din | output | 1 | Serial data to the first device |
| cs_n | output | 1 | Select/load, active low, rising edge loads |

## Verification
A slot counter that is off by one fetches the word for the wrong position. The error shows in the captured frame within 16 serial clocks, as data shifted into the wrong device. A bit counter that slips changes the number of rising edges before `cs_n` rises, so the error shows at the end of that same frame. A phase timer that reloads with the wrong count makes a high phase, low phase or select window shorter than its minimum. Measuring the run lengths in system cycles catches this within one serial clock period. The fetch-port model and the park substitution are checked by rebuilding each expected 16*CHAIN_LEN-bit frame in the bench from the words it supplied.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
  localparam int ADDR_W = 4;
  localparam int CODE_W = 10;
  localparam int PAD_W  = 2;
  localparam int WORD_W = ADDR_W + CODE_W + PAD_W;
  localparam logic [ADDR_W-1:0] SLEEP_ADDR = 4'b1110;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_HIGH, ST_LOW, ST_HOLD, ST_GAP
  } phase_t;

  // ceiling of ns / clk_ns, never below one cycle
  function automatic int cycles_for(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int at_least(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [WORD_W-1:0] sleep_word();
    return {SLEEP_ADDR, {(CODE_W + PAD_W){1'b0}}};
  endfunction
endpackage

// File: rtl/dcm_word_mux.sv
module dcm_word_mux
  import dcm_pkg::*;
#(
  parameter int CHAIN_LEN = 3,
  parameter int IDX_W     = 2
) (
  input  logic [WORD_W-1:0]    word_data,
  input  logic [CHAIN_LEN-1:0] park_mask,
  input  logic [IDX_W-1:0]     idx,
  output logic [WORD_W-1:0]    word_out
);
  logic parked;

  assign parked   = park_mask[idx];
  assign word_out = parked ? sleep_word() : word_data;
endmodule

// File: rtl/dcm_shift.sv
module dcm_shift
  import dcm_pkg::*;
#(
  parameter int CHAIN_LEN = 3,
  parameter int IDX_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic [WORD_W-1:0] word_in,
  output logic [IDX_W-1:0]  fetch_idx,
  output logic              frame_last,
  output logic              din
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(CHAIN_LEN - 1);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q;
  logic [BIT_W-1:0]  bit_q;
  logic [IDX_W-1:0]  slot_q;
  logic              word_end;
  logic              slot_first;

  assign word_end   = (bit_q == LAST_BIT);
  assign slot_first = (slot_q == '0);
  assign frame_last = word_end && slot_first;
  assign din        = sh_q[WORD_W-1];

  always_comb begin
    if (load)                        fetch_idx = LAST_SLOT;
    else if (word_end && !slot_first) fetch_idx = slot_q - IDX_W'(1);
    else                             fetch_idx = slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bit_q  <= '0;
      slot_q <= LAST_SLOT;
    end else if (load) begin
      sh_q   <= word_in;
      bit_q  <= '0;
      slot_q <= LAST_SLOT;
    end else if (advance) begin
      if (word_end) begin
        sh_q   <= word_in;
        bit_q  <= '0;
        slot_q <= slot_q - IDX_W'(1);
      end else begin
        sh_q   <= {sh_q[WORD_W-2:0], 1'b0};
        bit_q  <= bit_q + BIT_W'(1);
      end
    end
  end

  AST_ADVANCE_NOT_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> !frame_last) else $error("advance beyond frame end"); // R2
endmodule

// File: rtl/dcm_phase_ctl.sv
module dcm_phase_ctl
  import dcm_pkg::*;
#(
  parameter int HIGH_C  = 2,
  parameter int LOW_C   = 2,
  parameter int SETUP_C = 4,
  parameter int HOLD_C  = 2,
  parameter int GAP_C   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic frame_last,
  output logic sck,
  output logic cs_n,
  output logic busy,
  output logic done,
  output logic load,
  output logic advance
);
  localparam int MAX_C = at_least(at_least(at_least(HIGH_C, LOW_C),
                                           at_least(SETUP_C, HOLD_C)), GAP_C);
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam int RUN_W = CNT_W + 1;

  phase_t           st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             sck_q, cs_n_q, busy_q, done_q, cs_prev_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign load     = (st_q == ST_IDLE) && req;
  assign advance  = (st_q == ST_HIGH) && cnt_zero && !frame_last;
  assign sck      = sck_q;
  assign cs_n     = cs_n_q;
  assign busy     = busy_q;
  assign done     = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      sck_q     <= 1'b0;
      cs_n_q    <= 1'b1;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      cs_prev_q <= 1'b1;
    end else begin
      cs_prev_q <= cs_n_q;
      done_q    <= cs_n_q && !cs_prev_q;
      if (!cnt_zero) cnt_q <= cnt_q - CNT_W'(1);
      unique case (st_q)
        ST_IDLE: if (req) begin
          st_q   <= ST_SETUP;
          cs_n_q <= 1'b0;
          busy_q <= 1'b1;
          cnt_q  <= CNT_W'(SETUP_C - 1);
        end
        ST_SETUP: if (cnt_zero) begin
          st_q  <= ST_HIGH;
          sck_q <= 1'b1;
          cnt_q <= CNT_W'(HIGH_C - 1);
        end
        ST_HIGH: if (cnt_zero) begin
          sck_q <= 1'b0;
          if (frame_last) begin
            st_q  <= ST_HOLD;
            cnt_q <= CNT_W'(HOLD_C - 1);
          end else begin
            st_q  <= ST_LOW;
            cnt_q <= CNT_W'(LOW_C - 1);
          end
        end
        ST_LOW: if (cnt_zero) begin
          st_q  <= ST_HIGH;
          sck_q <= 1'b1;
          cnt_q <= CNT_W'(HIGH_C - 1);
        end
        ST_HOLD: if (cnt_zero) begin
          st_q   <= ST_GAP;
          cs_n_q <= 1'b1;
          cnt_q  <= CNT_W'(GAP_C - 1);
        end
        ST_GAP: if (cnt_zero) begin
          st_q   <= ST_IDLE;
          busy_q <= 1'b0;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // run length of the current sck level, for the phase-width checks
  logic             sck_seen_q;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_seen_q <= 1'b0;
      run_q      <= '1;
    end else begin
      sck_seen_q <= sck_q;
      if (sck_q != sck_seen_q) run_q <= RUN_W'(1);
      else if (run_q != '1)    run_q <= run_q + RUN_W'(1);
    end
  end

  AST_SCK_LOW_AT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_q) |-> (!sck_q && !$past(sck_q))) else $error("sck high at select"); // R2
  AST_NO_SCK_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    sck_q |-> !cs_n_q) else $error("sck while deselected"); // R2
  AST_HIGH_PHASE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_q && sck_seen_q) |-> (run_q >= RUN_W'(HIGH_C))) else $error("short high"); // R6
  AST_LOW_PHASE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_q && !sck_seen_q) |-> (run_q >= RUN_W'(LOW_C))) else $error("short low"); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q) else $error("done longer than one cycle"); // R10
  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (busy_q && cs_n_q)) else $error("done outside gap"); // R10
  AST_BUSY_HOLDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && req && !cs_n_q) |=> !load) else $error("request taken while busy"); // R9
endmodule

// File: rtl/dac_chain_master.sv
module dac_chain_master
  import dcm_pkg::*;
#(
  parameter int CHAIN_LEN       = 3,
  parameter int CLK_NS          = 20,
  parameter int SCK_DIV         = 1,
  parameter int T_SCK_HIGH_NS   = 30,
  parameter int T_SCK_LOW_NS    = 30,
  parameter int T_DIN_SETUP_NS  = 40,
  parameter int T_SEL_SETUP_NS  = 80,
  parameter int T_SEL_HOLD_NS   = 30,
  parameter int T_SEL_HIGH_NS   = 80,
  localparam int IDX_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req,
  output logic                 busy,
  output logic                 done,
  output logic [IDX_W-1:0]     word_idx,
  input  logic [WORD_W-1:0]    word_data,
  input  logic [CHAIN_LEN-1:0] park_mask,
  output logic                 sck,
  output logic                 din,
  output logic                 cs_n
);
  localparam int HIGH_C  = at_least(SCK_DIV, cycles_for(T_SCK_HIGH_NS, CLK_NS));
  localparam int LOW_C   = at_least(SCK_DIV, at_least(cycles_for(T_SCK_LOW_NS, CLK_NS),
                                                      cycles_for(T_DIN_SETUP_NS, CLK_NS)));
  localparam int SETUP_C = at_least(cycles_for(T_SEL_SETUP_NS, CLK_NS), LOW_C);
  localparam int HOLD_C  = cycles_for(T_SEL_HOLD_NS, CLK_NS);
  localparam int GAP_C   = cycles_for(T_SEL_HIGH_NS, CLK_NS);
  localparam int FRAME_BITS = WORD_W * CHAIN_LEN;
  localparam int FRAME_W    = $clog2(FRAME_BITS + 1);

  logic              load, advance, frame_last;
  logic [WORD_W-1:0] next_word;

  dcm_word_mux #(.CHAIN_LEN(CHAIN_LEN), .IDX_W(IDX_W)) mux_i (
    .word_data (word_data),
    .park_mask (park_mask),
    .idx       (word_idx),
    .word_out  (next_word)
  );

  dcm_shift #(.CHAIN_LEN(CHAIN_LEN), .IDX_W(IDX_W)) shift_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .advance    (advance),
    .word_in    (next_word),
    .fetch_idx  (word_idx),
    .frame_last (frame_last),
    .din        (din)
  );

  dcm_phase_ctl #(
    .HIGH_C (HIGH_C), .LOW_C (LOW_C), .SETUP_C (SETUP_C),
    .HOLD_C (HOLD_C), .GAP_C (GAP_C)
  ) ctl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .frame_last (frame_last),
    .sck        (sck),
    .cs_n       (cs_n),
    .busy       (busy),
    .done       (done),
    .load       (load),
    .advance    (advance)
  );

  // count of sck rises inside the current select window
  logic               sck_d;
  logic [FRAME_W-1:0] rise_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d    <= 1'b0;
      rise_cnt <= '0;
    end else begin
      sck_d <= sck;
      if (cs_n)              rise_cnt <= '0;
      else if (sck && !sck_d) rise_cnt <= rise_cnt + FRAME_W'(1);
    end
  end

  AST_FRAME_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> ($past(rise_cnt) == FRAME_W'(FRAME_BITS))) else $error("frame length"); // R2
  AST_DIN_STILL_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(din)) else $error("din moved during sck high"); // R6
endmodule

// File: tb/dac_chain_master_tb.sv
`timescale 1ns/1ps
module dac_chain_master_tb_top;
  localparam int M  = 3;
  localparam int T  = 20;
  localparam int FB = 16 * M;
  localparam int EXP_HIGH  = (30 + T - 1) / T;
  localparam int EXP_LOW   = (40 + T - 1) / T;
  localparam int EXP_SETUP = (80 + T - 1) / T;
  localparam int EXP_HOLD  = (30 + T - 1) / T;
  localparam int EXP_GAP   = (80 + T - 1) / T;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic busy, done, sck, din, cs_n;
  logic [1:0]   word_idx;
  logic [15:0]  word_data;
  logic [M-1:0] tb_park = '0;
  logic [15:0]  tb_words [M];

  int n_checks = 0, n_errors = 0, ncyc = 0;
  int n_frames = 0, n_done = 0;

  always #(T/2) clk = ~clk;

  assign word_data = tb_words[word_idx];

  dac_chain_master #(.CHAIN_LEN(M), .CLK_NS(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .busy(busy), .done(done),
    .word_idx(word_idx), .word_data(word_data), .park_mask(tb_park),
    .sck(sck), .din(din), .cs_n(cs_n)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor of the serial pins, sampled on the falling clock edge
  logic sck_p = 1'b0, cs_p = 1'b1, din_p = 1'b0;
  logic [FB-1:0] cap = '0;
  int  nbits = 0, t_fall = 0, t_rise = 0, t_sfall = 0, t_csrise = 0;
  bit  had_frame = 0, exp_done = 0;

  always @(negedge clk) begin
    ncyc++;
    if (ncyc > 150000) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", ncyc, 150000);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
    if (rst_n) begin
      if (exp_done) begin
        chk(done == 1'b1, "R10 done one cycle after cs_n rise", done, 1);
        exp_done = 0;
      end else if (done) begin
        chk(1'b0, "R10 done without cs_n rise", done, 0);
      end
      if (done) n_done++;
      if (sck && cs_n) chk(1'b0, "R2 sck high while deselected", sck, 0);
      if (cs_p && !cs_n) begin
        chk(!sck_p && !sck, "R2 sck low around select fall", {sck_p, sck}, 0);
        if (had_frame) chk(ncyc - t_csrise >= EXP_GAP, "R8 select high gap", ncyc - t_csrise, EXP_GAP);
        t_fall = ncyc; nbits = 0; cap = '0;
      end
      if (!cs_n && !sck_p && sck) begin
        if (nbits == 0) chk(ncyc - t_fall >= EXP_SETUP, "R7 select to first rise", ncyc - t_fall, EXP_SETUP);
        else chk(ncyc - t_sfall >= EXP_LOW, "R6 sck low width", ncyc - t_sfall, EXP_LOW);
        cap = {cap[FB-2:0], din};
        nbits++;
        t_rise = ncyc;
      end
      if (sck_p && !sck) begin
        chk(ncyc - t_rise >= EXP_HIGH, "R6 sck high width", ncyc - t_rise, EXP_HIGH);
        t_sfall = ncyc;
      end
      if (sck && sck_p) chk(din == din_p, "R6 din stable while sck high", din, din_p);
      if (!cs_p && cs_n) begin
        chk(nbits == FB, "R2 rising edges per frame", nbits, FB);
        chk(ncyc - t_sfall >= EXP_HOLD, "R7 last fall to select rise", ncyc - t_sfall, EXP_HOLD);
        chk(done == 1'b0, "R10 done not with cs_n rise", done, 0);
        t_csrise = ncyc; had_frame = 1; exp_done = 1;
        n_frames++;
      end
    end
    sck_p = sck; cs_p = cs_n; din_p = din;
  end

  function automatic logic [FB-1:0] exp_frame();
    logic [FB-1:0] f = '0;
    for (int s = M - 1; s >= 0; s--)
      f = {f[FB-17:0], (tb_park[s] ? 16'hE000 : tb_words[s])};
    return f;
  endfunction

  task automatic run_frame(input string tag, input bit poke_busy);
    int fb, nd;
    logic [FB-1:0] want;
    while (busy) @(negedge clk);
    fb = n_frames; nd = n_done;
    want = exp_frame();
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk(busy == 1'b1, "R10 busy after accept", busy, 1);
    if (poke_busy) begin
      repeat (30) @(negedge clk);
      req = 1'b1; @(negedge clk); req = 1'b0;
    end
    while (n_frames == fb) @(negedge clk);
    if (poke_busy) begin
      req = 1'b1; @(negedge clk); req = 1'b0;
    end
    repeat (2) @(negedge clk);
    chk(cap == want, tag, cap, want);
    chk(n_done == nd + 1, "R10 one done per frame", n_done - nd, 1);
    if (poke_busy) begin
      while (busy) @(negedge clk);
      repeat (30) @(negedge clk);
      chk(n_frames == fb + 1 && cs_n, "R9 busy request ignored", n_frames - fb, 1);
    end
  endtask

  initial begin
    for (int s = 0; s < M; s++) tb_words[s] = '0;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sck == 1'b0, "R1 pins in reset", {cs_n, sck}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && cs_n && !sck, "R1 idle after reset",
        {busy, done, cs_n, sck}, 4'b0010);

    // walking one through every bit of every slot
    for (int b = 0; b < 16; b++) begin
      for (int s = 0; s < M; s++) tb_words[s] = 16'h1 << ((b + 5 * s) % 16);
      run_frame("R3 R4 walking bit frame", 0);
    end
    // distinct words per slot, every park pattern
    tb_words[0] = 16'h1A5C; tb_words[1] = 16'h2F03; tb_words[2] = 16'hF7FD;
    for (int p = 0; p < (1 << M); p++) begin
      tb_park = p[M-1:0];
      run_frame(p == 0 ? "R4 slot order frame" : "R5 parked slot frame", 0);
    end
    tb_park = '0;
    for (int s = 0; s < M; s++) tb_words[s] = 16'hFFFF;
    run_frame("R3 all ones frame", 0);
    for (int s = 0; s < M; s++) tb_words[s] = 16'h0000;
    run_frame("R3 all zeros frame", 0);
    tb_words[0] = 16'h4123; tb_words[1] = 16'h0ABC; tb_words[2] = 16'h3555;
    tb_park = 3'b010;
    run_frame("R9 frame with busy requests", 1);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule